// File: doc/BRIEF.md
# Triggered Four-Pixel Hit Buffer

This block is the digital logic shared by a group of four pixel channels. Each channel's hit signal is the discriminator output masked by a per-channel enable, ORed with a digital test-hit injection line. The block measures how many clock ticks each gated hit stays high (time over threshold, ToT). It stamps every new hit event with one counter from a small shared pool of latency countdown counters.

Each counter owns one ToT slot per pixel. When a counter has counted down to zero, the trigger input decides what happens to the record. If the trigger is high in that cycle, the record waits in its slot and is then sent out on a valid/ready port. If it is low, the record is dropped. In both cases the counter and its slots go back to the pool. Latency is counted in bunch-clock ticks, and the countdown start value comes from the `latency` input at the moment a counter is claimed.

Top module: `pix_region_buf`

## Requirements
- R1: The gated hit of pixel p is `(disc[p] & enable[p]) | inject[p]`. A disabled pixel's discriminator claims no counter and adds no ToT. An injected hit counts even when the pixel is disabled.
- R2: A rising gated hit on any pixel claims the lowest-numbered free counter. The index of the claimed counter appears as `out_idx` on the record. Pixels that rise at the same clock edge share one counter. Pixels that did not rise in that event report ToT 0.
- R3: If a hit rises while every counter is busy, it is dropped and produces no record. `overflow` goes high and stays high until reset.
- R4: The hit's rising edge is sampled at clock edge P. The trigger is high at edge P+L+1, where L is the latency value at edge P. In that case the record is presented with `out_valid` high from edge P+L+2, and not before.
- R5: If the trigger is low at edge P+L+1, no record is ever produced for that event, and the counter is freed.
- R6: A pixel's ToT is the number of clock edges at which its gated hit was sampled high, saturating at 15. `out_tot[4p+3:4p]` carries pixel p.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_idx` and `out_tot` hold. Records that become ready in the meantime wait and are sent in later cycles, lowest counter index first.
- R8: A counter freed at edge E cannot be claimed at edge E. It can be claimed from edge E+1 onward.
- R9: After reset, `out_valid` and `overflow` are low and all counters are free.
- R10: A trigger at any edge other than P+L+1 has no effect on that event.
- R11: If a pixel is still high when its counter expires, that pixel reports ToT 0 in the record. Its later falling edge does not change any record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latency | input | LATW | Countdown start value loaded on claim |
| enable | input | NPIX | Per-pixel discriminator enable |
| disc | input | NPIX | Discriminator outputs |
| inject | input | NPIX | Digital test-hit injection |
| trigger | input | 1 | Trigger decision |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts record |
| out_tot | output | NPIX*TOTW | Per-pixel ToT, pixel 0 in the low bits |
| out_idx | output | IDXW | Counter index of the record |
| overflow | output | 1 | Sticky: a hit found no free counter |

## Verification
The hardest situation to reach is a counter that frees up at the same edge a new hit arrives. Here the hit must skip the freshly freed counter, and the next hit must take it. The stimulus fills three counters with short pulses spaced two cycles apart. It lets the first one expire without a trigger. It then places new rising edges exactly on the expiry edge and on the edge after it, and triggers both later expiries so the indices show up on the record port. Overflow is reached by six spaced pulses while the trigger is held high, and the test counts that exactly five records come out.

// File: rtl/pix_region_buf.sv
module pix_region_buf #(
  parameter int NPIX = 4,
  parameter int NCNT = 5,
  parameter int TOTW = 4,
  parameter int LATW = 8,
  localparam int IDXW = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LATW-1:0]      latency,
  input  logic [NPIX-1:0]      enable,
  input  logic [NPIX-1:0]      disc,
  input  logic [NPIX-1:0]      inject,
  input  logic                 trigger,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NPIX*TOTW-1:0] out_tot,
  output logic [IDXW-1:0]      out_idx,
  output logic                 overflow
);
  localparam logic [TOTW-1:0] TOTMAX = {TOTW{1'b1}};

  logic [NPIX-1:0] hit, hit_q, rise, fall, pv;
  logic [NCNT-1:0] busy, waitq, expire;
  logic [LATW-1:0] cnt [NCNT];
  logic [TOTW-1:0] slot_tot [NCNT][NPIX];
  logic [TOTW-1:0] tot [NPIX];
  logic [IDXW-1:0] pslot [NPIX];
  logic [IDXW-1:0] claim_idx, pick_idx;
  logic claim_ok, pick_ok, new_evt, load;

  assign hit     = (disc & enable) | inject;
  assign rise    = hit & ~hit_q;
  assign fall    = ~hit & hit_q;
  assign new_evt = |rise;

  always_comb begin
    claim_ok  = 1'b0;
    claim_idx = '0;
    pick_ok   = 1'b0;
    pick_idx  = '0;
    for (int i = NCNT - 1; i >= 0; i--) begin
      expire[i] = busy[i] & ~waitq[i] & (cnt[i] == '0);
      if (!busy[i]) begin
        claim_ok  = 1'b1;
        claim_idx = IDXW'(i);
      end
      if (waitq[i]) begin
        pick_ok  = 1'b1;
        pick_idx = IDXW'(i);
      end
    end
  end

  assign load = pick_ok & (~out_valid | out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q     <= '0;
      busy      <= '0;
      waitq     <= '0;
      pv        <= '0;
      overflow  <= 1'b0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_tot   <= '0;
      for (int i = 0; i < NCNT; i++) begin
        cnt[i] <= '0;
        for (int p = 0; p < NPIX; p++) slot_tot[i][p] <= '0;
      end
      for (int p = 0; p < NPIX; p++) begin
        tot[p]   <= '0;
        pslot[p] <= '0;
      end
    end else begin
      hit_q <= hit;
      if (new_evt && !claim_ok) overflow <= 1'b1;

      for (int i = 0; i < NCNT; i++) begin
        if (busy[i] && !waitq[i]) begin
          if (cnt[i] == '0) begin
            if (trigger) waitq[i] <= 1'b1;
            else         busy[i]  <= 1'b0;
          end else begin
            cnt[i] <= cnt[i] - 1'b1;
          end
        end
        if (load && pick_idx == IDXW'(i)) begin
          busy[i]  <= 1'b0;
          waitq[i] <= 1'b0;
        end
        if (new_evt && claim_ok && claim_idx == IDXW'(i)) begin
          busy[i]  <= 1'b1;
          waitq[i] <= 1'b0;
          cnt[i]   <= latency;
          for (int p = 0; p < NPIX; p++) slot_tot[i][p] <= '0;
        end
      end

      for (int p = 0; p < NPIX; p++) begin
        if (rise[p])                        tot[p] <= 1;
        else if (hit[p] && tot[p] != TOTMAX) tot[p] <= tot[p] + 1'b1;
        if (pv[p] && fall[p]) begin
          slot_tot[pslot[p]][p] <= tot[p];
          pv[p] <= 1'b0;
        end
        if (pv[p] && expire[pslot[p]]) pv[p] <= 1'b0;
        if (rise[p] && claim_ok) begin
          pv[p]    <= 1'b1;
          pslot[p] <= claim_idx;
        end
      end

      if (load) begin
        out_valid <= 1'b1;
        out_idx   <= pick_idx;
        for (int p = 0; p < NPIX; p++) out_tot[p*TOTW +: TOTW] <= slot_tot[pick_idx][p];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pix_region_buf_chk.sv
module pix_region_buf_chk #(
  parameter int NPIX = 4,
  parameter int NCNT = 5,
  parameter int TOTW = 4,
  parameter int IDXW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NPIX*TOTW-1:0] out_tot,
  input logic [IDXW-1:0]      out_idx,
  input logic                 overflow,
  input logic [NCNT-1:0]      busy,
  input logic [NCNT-1:0]      waitq
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_tot));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_ovf_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(&busy));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_idx} < (IDXW + 1)'(NCNT)));

  p_rec_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(|waitq));

  p_wait_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waitq & ~busy) == '0);
endmodule

bind pix_region_buf pix_region_buf_chk #(
  .NPIX(NPIX), .NCNT(NCNT), .TOTW(TOTW), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_tot(out_tot), .out_idx(out_idx), .overflow(overflow),
  .busy(busy), .waitq(waitq)
);

// File: tb/sim_pix_region_buf.sv
module sim_pix_region_buf;
  localparam int L = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] latency = 8'(L);
  logic [3:0] enable = 4'hF, disc = '0, inject = '0;
  logic trigger = 1'b0, out_ready = 1'b1;
  logic out_valid, overflow;
  logic [15:0] out_tot;
  logic [2:0] out_idx;
  int edge_no = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  pix_region_buf u0 (
    .clk(clk), .rst_n(rst_n), .latency(latency), .enable(enable), .disc(disc),
    .inject(inject), .trigger(trigger), .out_valid(out_valid), .out_ready(out_ready),
    .out_tot(out_tot), .out_idx(out_idx), .overflow(overflow)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic at(input int k);
    while (edge_no < k) tick();
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edge_no);
    end
  endtask

  task automatic check_rec(input string req, input logic [2:0] idx, input logic [15:0] t);
    check(out_valid == 1'b1, req, 32'(out_valid), 1);
    check(out_idx == idx, req, 32'(out_idx), 32'(idx));
    check(out_tot == t, req, 32'(out_tot), 32'(t));
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
    check(overflow == 1'b0, "R9 overflow", 32'(overflow), 0);
  endtask

  task automatic t_basic();
    int p = edge_no + 1;
    disc = 4'b0101;
    at(p + 2); disc = 4'b0100;
    at(p + 4); disc = 4'b0000;
    at(p + L); trigger = 1'b1;
    at(p + L + 1); trigger = 1'b0;
    check(out_valid == 1'b0, "R4 early", 32'(out_valid), 0);
    at(p + L + 2);
    check_rec("R4 R6 R2 basic", 3'd0, 16'h0503);
    at(p + L + 3);
    check(out_valid == 1'b0, "R4 consumed", 32'(out_valid), 0);
  endtask

  task automatic t_hold();
    int p = edge_no + 1;
    out_ready = 1'b0;
    disc = 4'b1000;
    at(p + 1); disc = 4'b0010;
    at(p + 2); disc = 4'b0000;
    at(p + L); trigger = 1'b1;
    at(p + L + 1); trigger = 1'b0;
    at(p + L + 2); trigger = 1'b1;
    check_rec("R7 first", 3'd0, 16'h2000);
    at(p + L + 3); trigger = 1'b0;
    at(p + L + 6);
    check_rec("R7 held", 3'd0, 16'h2000);
    out_ready = 1'b1;
    at(p + L + 7);
    check_rec("R7 second", 3'd1, 16'h0010);
    at(p + L + 8);
    check(out_valid == 1'b0, "R7 drained", 32'(out_valid), 0);
  endtask

  task automatic t_notrig();
    int p = edge_no + 1;
    int seen = 0;
    disc = 4'b0001;
    at(p); disc = 4'b0000;
    at(p + L - 1); trigger = 1'b1;
    at(p + L); trigger = 1'b0;
    if (out_valid) seen++;
    at(p + L + 1); trigger = 1'b1;
    at(p + L + 2); trigger = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (out_valid) seen++;
      tick();
    end
    check(seen == 0, "R5 R10 no record", 32'(seen), 0);
  endtask

  task automatic t_gate();
    int p = edge_no + 1;
    int seen = 0;
    enable = 4'b1100;
    disc = 4'b0101;
    inject = 4'b0010;
    at(p + 1); inject = 4'b0000;
    at(p + 3); disc = 4'b0000;
    at(p + L); trigger = 1'b1;
    at(p + L + 1); trigger = 1'b0;
    at(p + L + 2);
    check_rec("R1 gating", 3'd0, 16'h0420);
    p = edge_no + 1;
    disc = 4'b0001;
    at(p + 1); disc = 4'b0000; trigger = 1'b1;
    for (int k = 0; k < L + 6; k++) begin
      tick();
      if (out_valid) seen++;
    end
    trigger = 1'b0;
    check(seen == 0, "R1 masked pixel", 32'(seen), 0);
    enable = 4'hF;
  endtask

  task automatic t_sat();
    int p = edge_no + 1;
    disc = 4'b1001;
    at(p + 13); disc = 4'b1000;
    at(p + 17); disc = 4'b0000;
    at(p + L); trigger = 1'b1;
    at(p + L + 1); trigger = 1'b0;
    at(p + L + 2);
    check_rec("R6 saturate", 3'd0, 16'hF00E);
  endtask

  task automatic t_still();
    int p = edge_no + 1;
    disc = 4'b0110;
    at(p); disc = 4'b0010;
    at(p + L); trigger = 1'b1;
    at(p + L + 1); trigger = 1'b0;
    at(p + L + 2);
    check_rec("R11 still high", 3'd0, 16'h0100);
    disc = 4'b0000;
    at(p + L + 6);
    check(out_valid == 1'b0, "R11 late fall", 32'(out_valid), 0);
  endtask

  task automatic t_reuse();
    int p = edge_no + 1;
    disc = 4'b0001;
    at(p);     disc = 4'b0000;
    at(p + 1); disc = 4'b0001;
    at(p + 2); disc = 4'b0000;
    at(p + 3); disc = 4'b0001;
    at(p + 4); disc = 4'b0000;
    at(p + L);     disc = 4'b0010;
    at(p + L + 1); disc = 4'b0100;
    at(p + L + 2); disc = 4'b0000;
    at(p + 2 * L + 1); trigger = 1'b1;
    at(p + 2 * L + 3); trigger = 1'b0;
    check_rec("R8 same-edge free skipped", 3'd3, 16'h0010);
    at(p + 2 * L + 4);
    check_rec("R2 R8 lowest reused", 3'd0, 16'h0100);
    at(p + 2 * L + 6);
  endtask

  task automatic t_overflow();
    int p = edge_no + 1;
    int recs = 0;
    disc = 4'b0001;
    for (int k = 0; k < 6; k++) begin
      at(p + 2 * k); disc = 4'b0000;
      if (k < 5) begin
        at(p + 2 * k + 1); disc = 4'b0001;
      end
      if (k == 4) check(overflow == 1'b0, "R3 not yet", 32'(overflow), 0);
    end
    check(overflow == 1'b1, "R3 set", 32'(overflow), 1);
    trigger = 1'b1;
    while (edge_no < p + L + 16) begin
      tick();
      if (out_valid && out_ready) recs++;
    end
    trigger = 1'b0;
    check(recs == 5, "R3 dropped hit", 32'(recs), 5);
    check(overflow == 1'b1, "R3 sticky", 32'(overflow), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_hold();
    t_notrig();
    t_gate();
    t_sat();
    t_still();
    t_reuse();
    t_overflow();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule